// File: doc/BRIEF.md
# Audio Serial-Port Master Clock Generator

This block produces the serial bit clock and the frame (word-select) clock of an audio serial port that runs as clock master. Both clocks are divided down from the fast reference clock the block runs on. A third output gives a one-reference-cycle strobe at the start of every bit period. A data serializer uses that strobe to launch its next bit on the falling edge of the serial clock.

Software writes one 32-bit control word through a plain write port. The word holds the enable, the framing style, the frame length and the serial-clock divider. The framing style is either two-channel (a 50 % duty word-select) or multi-slot (a single-bit-period frame pulse).

A new word is held in a shadow register. Its framing fields take effect only at a frame boundary, so a frame is never cut short or stretched part-way through. Clearing the enable is handled faster: the clocks stop at the end of the current bit period. The block has no streaming data path, so every pin is a plain level or strobe with no handshake.

Top module: `audio_mclk_gen`

## Requirements
- R1: While reset is held, and after it is released until a valid enabling word has been written, `sck_o`, `ws_o` and `sck_fall_o` are all low.
- R2: Control word layout: bit 0 is the enable (1 = run), bit 1 is the framing style (0 = two-channel, 1 = multi-slot), bits 10:2 are the frame length in serial-clock periods and bits 21:11 are the divider in reference cycles per serial-clock period. Bits 31:22 have no effect. A word with bit 0 clear keeps all outputs low.
- R3: With divider D ≥ 2, every serial-clock period lasts D reference cycles. Within a period `sck_o` is low for the first D − floor(D/2) cycles and high for the remaining floor(D/2) cycles, so an odd D gives a high phase one cycle shorter than the low phase.
- R4: A divider of 0 or 1 keeps all three outputs low even when enabled.
- R5: `sck_fall_o` is high for exactly one reference cycle: the first cycle of every serial-clock period, including the first period after a start.
- R6: Two-channel framing with frame length F: `ws_o` is low for the first F − floor(F/2) bit periods of a frame and high for the rest. It changes only in a cycle where `sck_fall_o` is high.
- R7: Multi-slot framing with frame length F: `ws_o` is high during the last bit period of each frame only, which is the period just before slot 0's first bit.
- R8: A frame length field of 0 or 1 behaves as a frame length of 2.
- R9: If the write is sampled at clock edge k, the first bit period (bit 0 of frame 0) is visible on the outputs after edge k+1, provided the block was idle.
- R10: Clearing the enable stops both clocks low at the end of the bit period in progress, within D reference cycles. The counters return to zero, so re-enabling starts again at bit 0 of a new frame.
- R11: A word written while running, with the enable still set, takes effect at the next frame boundary. The current frame completes with the old settings. A divider below 2 in that word stops the block at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Frame / word-select clock |
| sck_fall_o | output | 1 | One-cycle strobe at each serial-clock falling edge |

## Verification
The in-RTL assertions watch the following on every cycle:
- the strobe lasts one cycle and lines up with every falling edge of the serial clock;
- word-select changes only on that strobe;
- the multi-slot pulse sits on the last bit of the frame;
- an idle block drives nothing;
- a cleared enable stops the clocks within one divider period;
- the active settings change only on a bit boundary.

The exact duty split for odd dividers and the word-select position within the frame need the bench, which compares each cycle of every divider and frame-length combination in a small sweep against an arithmetic model. The bench also covers:
- the two-cycle start latency;
- the frame at which a word changed mid-run takes effect;
- resumption from bit 0 after a stop.

// File: rtl/amcg_pkg.sv
`timescale 1ns/1ps
package amcg_pkg;
  localparam int DIV_W    = 11;
  localparam int FLEN_W   = 9;
  localparam int CFG_BITS = 2 + FLEN_W + DIV_W;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [FLEN_W-1:0] flen;
    logic              tdm;
    logic              en;
  } mclk_cfg_t;

  function automatic mclk_cfg_t unpack_cfg(input logic [CFG_BITS-1:0] w);
    mclk_cfg_t r;
    r.en   = w[0];
    r.tdm  = w[1];
    r.flen = w[2 +: FLEN_W];
    r.div  = w[2+FLEN_W +: DIV_W];
    return r;
  endfunction

  // frame lengths below two are promoted to two
  function automatic logic [FLEN_W-1:0] eff_flen(input logic [FLEN_W-1:0] f);
    return (f < FLEN_W'(2)) ? FLEN_W'(2) : f;
  endfunction
endpackage

// File: rtl/amcg_cfg_reg.sv
`timescale 1ns/1ps
module amcg_cfg_reg
  import amcg_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output mclk_cfg_t        shadow_o
);
  localparam int RSVD_LO = CFG_BITS;

  // reserved upper bits are dropped here (R2)
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[CTL_W-1:RSVD_LO];

  always_ff @(posedge clk) begin
    if (!rst_n)  shadow_o <= '0;
    else if (we) shadow_o <= unpack_cfg(wdata[CFG_BITS-1:0]);
  end
endmodule

// File: rtl/amcg_bit_div.sv
`timescale 1ns/1ps
module amcg_bit_div
  import amcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             keep,
  input  logic [DIV_W-1:0] div_cur,
  input  logic [DIV_W-1:0] div_nxt,
  output logic             wrap_o,
  output logic             sck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n, low_n;
  logic             run_n, run_q;

  assign wrap_o = (cnt_q == div_cur - DIV_W'(1));

  always_comb begin
    run_n = start | keep;
    cnt_n = (keep && !wrap_o) ? cnt_q + DIV_W'(1) : '0;
    low_n = div_nxt - (div_nxt >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      sck_o  <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      sck_o  <= run_n && (cnt_n >= low_n);
      fall_o <= run_n && (cnt_n == '0);
    end
  end

  // R5
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
  // R5
  fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sck_o) && run_q) |-> fall_o);
  // R3
  fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !sck_o);
endmodule

// File: rtl/amcg_frame_seq.sv
`timescale 1ns/1ps
module amcg_frame_seq
  import amcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              keep,
  input  logic              step,
  input  logic [FLEN_W-1:0] flen_cur,
  input  logic              tdm_cur,
  input  logic [FLEN_W-1:0] flen_nxt,
  input  logic              tdm_nxt,
  output logic              frame_end_o,
  output logic              ws_o
);
  logic [FLEN_W-1:0] bit_q, bit_n, fcur, fnxt;
  logic              run_n, run_q, ws_n;

  assign fcur        = eff_flen(flen_cur);
  assign frame_end_o = (bit_q == fcur - FLEN_W'(1));

  always_comb begin
    run_n = start | keep;
    fnxt  = eff_flen(flen_nxt);
    if (keep && step) bit_n = frame_end_o ? '0 : bit_q + FLEN_W'(1);
    else if (keep)    bit_n = bit_q;
    else              bit_n = '0;
    if (tdm_nxt) ws_n = (bit_n == fnxt - FLEN_W'(1));
    else         ws_n = (bit_n >= fnxt - (fnxt >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      run_q <= 1'b0;
      ws_o  <= 1'b0;
    end else begin
      bit_q <= bit_n;
      run_q <= run_n;
      ws_o  <= run_n && ws_n;
    end
  end

  // R7
  tdm_pulse_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tdm_cur && ws_o) |-> frame_end_o);
  // R8
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (bit_q < fcur));
endmodule

// File: rtl/audio_mclk_gen.sv
`timescale 1ns/1ps
module audio_mclk_gen
  import amcg_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             sck_o,
  output logic             ws_o,
  output logic             sck_fall_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  mclk_cfg_t        sh, act_q, act_n;
  logic             running_q, start, keep, wrap, frame_end;
  logic [DIV_W:0]   stop_wait_q;

  amcg_cfg_reg #(.CTL_W(CTL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .shadow_o(sh)
  );

  // sequencing: idle tracks the shadow; running reloads only at frame end
  always_comb begin
    start = 1'b0;
    keep  = 1'b0;
    act_n = act_q;
    if (!running_q) begin
      act_n = sh;
      start = sh.en && (sh.div >= MIN_DIV);
    end else if (!wrap) begin
      keep = 1'b1;
    end else if (!sh.en) begin
      keep = 1'b0;
    end else if (frame_end) begin
      if (sh.div >= MIN_DIV) begin
        keep  = 1'b1;
        act_n = sh;
      end
    end else begin
      keep = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      act_q     <= '0;
    end else begin
      running_q <= start | keep;
      act_q     <= act_n;
    end
  end

  amcg_bit_div u_bdiv (
    .clk(clk), .rst_n(rst_n), .start(start), .keep(keep),
    .div_cur(act_q.div), .div_nxt(act_n.div),
    .wrap_o(wrap), .sck_o(sck_o), .fall_o(sck_fall_o)
  );

  amcg_frame_seq u_fseq (
    .clk(clk), .rst_n(rst_n), .start(start), .keep(keep), .step(wrap),
    .flen_cur(act_q.flen), .tdm_cur(act_q.tdm),
    .flen_nxt(act_n.flen), .tdm_nxt(act_n.tdm),
    .frame_end_o(frame_end), .ws_o(ws_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   stop_wait_q <= '0;
    else if (running_q && !sh.en) stop_wait_q <= stop_wait_q + 1'b1;
    else                          stop_wait_q <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (!sck_o && !ws_o && !sck_fall_o));
  // R2
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> act_q.en);
  // R6
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !$stable(ws_o)) |-> sck_fall_o);
  // R10
  stop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (stop_wait_q < {1'b0, act_q.div}));
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !$stable(act_q)) |-> sck_fall_o);
endmodule

// File: tb/audio_mclk_gen_tb.sv
`timescale 1ns/1ps
module audio_mclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        sck_o, ws_o, sck_fall_o;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  audio_mclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sck_o(sck_o), .ws_o(ws_o), .sck_fall_o(sck_fall_o)
  );

  function automatic logic [31:0] mkword(bit en, bit tdm, int f, int d);
    return 32'(en) | (32'(tdm) << 1) | (32'(f) << 2) | (32'(d) << 11);
  endfunction

  // {sck, ws, fall} at cycle t after start
  function automatic logic [2:0] model(int d, int f, bit tdm, int t);
    int fe = (f < 2) ? 2 : f;
    int c  = t % d;
    int b  = (t / d) % fe;
    logic s, w, fl;
    s  = (c >= d - d/2);
    fl = (c == 0);
    w  = tdm ? (b == fe - 1) : (b >= fe - fe/2);
    return {s, w, fl};
  endfunction

  task automatic cmp(logic [2:0] exp, string tag);
    logic [2:0] got = {sck_o, ws_o, sck_fall_o};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got sck/ws/fall=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(logic [31:0] w);
    ctl_we = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic follow(int d, int f, bit tdm, int t0, int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(model(d, f, tdm, t0 + i), tag);
    end
  endtask

  initial begin
    int dl[5] = '{2, 3, 4, 5, 7};
    int fl[7] = '{0, 1, 2, 3, 4, 5, 8};

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    cmp(3'b000, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) begin @(negedge clk); cmp(3'b000, "R1 after reset"); end

    // R3 R5 R6 R7 R8 R9 R2: sweep divider, frame length, framing
    for (int m = 0; m < 2; m++) begin
      for (int di = 0; di < 5; di++) begin
        for (int fi = 0; fi < 7; fi++) begin
          int fe;
          logic [31:0] w;
          fe = (fl[fi] < 2) ? 2 : fl[fi];
          w = mkword(1'b1, m[0], fl[fi], dl[di]);
          if (((di + fi) % 2) == 1) w = w | 32'hFFC0_0000; // R2 reserved
          do_reset();
          wr(w);
          follow(dl[di], fl[fi], m[0], 0, 2 * dl[di] * fe,
                 m[0] ? "R7 R3 R5 R9 sweep multi-slot" : "R6 R3 R5 R8 sweep two-channel");
        end
      end
    end

    // R4: divider 0 and 1 hold outputs low; R2: enable clear holds low
    for (int k = 0; k < 3; k++) begin
      do_reset();
      wr((k < 2) ? mkword(1'b1, 1'b0, 4, k) : mkword(1'b0, 1'b0, 4, 4));
      repeat (30) begin
        @(negedge clk);
        cmp(3'b000, (k < 2) ? "R4 tiny divider" : "R2 enable clear");
      end
    end

    // R10: clear enable mid bit period, then restart from bit 0
    do_reset();
    wr(mkword(1'b1, 1'b0, 4, 4));
    follow(4, 4, 1'b0, 0, 10, "R10 pre-stop");
    wr(mkword(1'b0, 1'b0, 4, 4));
    cmp(model(4, 4, 1'b0, 10), "R10 finish period");
    follow(4, 4, 1'b0, 11, 1, "R10 finish period");
    repeat (10) begin @(negedge clk); cmp(3'b000, "R10 stopped low"); end
    wr(mkword(1'b1, 1'b0, 4, 4));
    follow(4, 4, 1'b0, 0, 32, "R10 restart at bit 0");

    // R11: change settings mid-frame, applied at the frame boundary
    do_reset();
    wr(mkword(1'b1, 1'b0, 4, 2));
    follow(2, 4, 1'b0, 0, 5, "R11 old frame");
    wr(mkword(1'b1, 1'b1, 3, 3));
    cmp(model(2, 4, 1'b0, 5), "R11 old frame");
    follow(2, 4, 1'b0, 6, 2, "R11 old frame end");
    follow(3, 3, 1'b1, 0, 18, "R11 new frame");

    // R11: divider below 2 written mid-run stops at the frame boundary
    do_reset();
    wr(mkword(1'b1, 1'b0, 2, 3));
    follow(3, 2, 1'b0, 0, 2, "R11 pre");
    wr(mkword(1'b1, 1'b0, 2, 1));
    cmp(model(3, 2, 1'b0, 2), "R11 pre");
    follow(3, 2, 1'b0, 3, 3, "R11 finish frame");
    repeat (8) begin @(negedge clk); cmp(3'b000, "R11 stopped by tiny divider"); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule